// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is a 16-bit timer that advances on tick enables within a single system clock domain. One of four tick sources is selected and then divided by 1, 2, 4 or 8. The divided tick drives a counter that can run in one of four modes: halted, a repeating ramp from 0 to a programmable period, a free-running 16-bit ramp, or a triangle that climbs to the period and falls back to 0.

Each time a cycle of the chosen mode completes, a sticky flag is set. The flag stays set until a clear-flag pulse removes it. An interrupt request is the flag gated by an enable. A one-cycle clear command restarts the count, the prescaler phase and the direction together.

Every pin is a plain control or status level, or a single-cycle pulse. No streamed data enters or leaves the block, so there is no valid/ready handshake and no back-pressure. Software-visible registers and the crossing of tick sources from other clock domains belong to the surrounding logic.

Top module: `tmr_core`

## Requirements
- R1: After reset, the count is 0, the direction is up (`dir_down_o` = 0), and `flag_o`, `irq_o`, `period_hit_o` and `zero_hit_o` are all 0.
- R2: Only the source bit `src_tick_i[src_sel_i]` advances the timer, where the select code is the bit index (0 to 3). Pulses on the other source bits change nothing.
- R3: Divider code 0, 1, 2 or 3 makes the counter step once every 1, 2, 4 or 8 selected source ticks, counted from the last clear command.
- R4: Mode code 0 (stop) holds the count, the direction and the prescaler phase, even while source ticks arrive. Leaving stop mode resumes from the held values.
- R5: Mode code 1 (up) increments the count on each divided tick. A tick that finds the count at or above `period_i` loads 0 instead and sets the flag.
- R6: Mode code 2 (free-running) increments on each divided tick through 0xFFFF. The tick that wraps 0xFFFF to 0 sets the flag.
- R7: Mode code 3 (triangle) counts up. The tick that brings the count to `period_i` sets the direction to down. Later ticks decrement, and the tick that reaches 0 sets the flag and the direction back to up. With period P, the triangle repeats every 2P divided ticks.
- R8: A cycle with `clr_i` high sets the count to 0, the prescaler phase to 0 and the direction to up. Any tick in that same cycle is discarded. The flag is not changed.
- R9: `period_hit_o` is high for exactly the one cycle after a divided tick leaves the count equal to `period_i`. `zero_hit_o` is high for exactly the one cycle after a divided tick leaves the count at 0.
- R10: The flag stays set until a cycle with `flag_clr_i` high. When a set event and `flag_clr_i` occur in the same cycle, the flag stays set.
- R11: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | One tick enable per clock source |
| src_sel_i | input | 2 | Tick source select (bit index) |
| div_sel_i | input | 2 | Prescaler code, divide by 2^code |
| mode_i | input | 2 | 0 stop, 1 up, 2 free-running, 3 triangle |
| clr_i | input | 1 | One-cycle restart of count, prescaler and direction |
| period_i | input | 16 | Period value for up and triangle modes |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle clear of the sticky flag |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while the triangle is falling |
| period_hit_o | output | 1 | Pulse: count just became equal to the period |
| zero_hit_o | output | 1 | Pulse: count just became 0 |
| flag_o | output | 1 | Sticky cycle-complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The free-running wrap is the hardest case to reach from the ports. No preload input exists, so the count has to pass through all 65,536 values. The stimulus reaches it by holding a tick source high at divide-by-1 for just over 65,536 cycles, and it checks the flag and `zero_hit_o` on the wrap cycle. Two other cases need careful alignment. Stopping with the prescaler midway through a divide-by-4 window is one. Clearing the flag in the same cycle that a triangle reaches 0 is the other. Both are produced by counting exact numbers of source pulses after a clear command.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_TRI  = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int NUM_SRC = 4,
  parameter int DIV_W   = 2,
  localparam int SEL_W  = $clog2(NUM_SRC),
  localparam int PRE_W  = (1 << DIV_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [DIV_W-1:0]   div_sel_i,
  input  logic               run_i,
  input  logic               clr_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             src_hit;

  assign src_hit = src_tick_i[src_sel_i];

  // low bits of the phase that must all be ones before a divided tick
  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(div_sel_i));
  end

  assign tick_o = run_i && src_hit && !clr_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clr_i)            pre_q <= '0;
    else if (run_i && src_hit) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             period_hit_o,
  output logic             zero_hit_o,
  output logic             cycle_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             dir_q, dir_n;
  logic             evt;
  logic             per_hit_q, zero_hit_q;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    evt   = 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          dir_n = 1'b0;
          if (cnt_q >= period_i) begin
            cnt_n = '0;
            evt   = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        MODE_FREE: begin
          dir_n = 1'b0;
          cnt_n = cnt_q + 1'b1;
          evt   = (cnt_q == '1);
        end
        MODE_TRI: begin
          if (!dir_q && (cnt_q < period_i)) begin
            cnt_n = cnt_q + 1'b1;
            dir_n = ((cnt_q + 1'b1) == period_i);
          end else if (cnt_q <= CNT_W'(1)) begin
            cnt_n = '0;
            dir_n = 1'b0;
            evt   = 1'b1;
          end else begin
            cnt_n = cnt_q - 1'b1;
            dir_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      per_hit_q  <= 1'b0;
      zero_hit_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      per_hit_q  <= 1'b0;
      zero_hit_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_n;
      dir_q      <= dir_n;
      per_hit_q  <= tick_i && (cnt_n == period_i);
      zero_hit_q <= tick_i && (cnt_n == '0);
    end
  end

  assign count_o      = cnt_q;
  assign dir_down_o   = dir_q;
  assign period_hit_o = per_hit_q;
  assign zero_hit_o   = zero_hit_q;
  assign cycle_evt_o  = evt && !clr_i;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4,
  parameter int DIV_W   = 2,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [DIV_W-1:0]   div_sel_i,
  input  logic [1:0]         mode_i,
  input  logic               clr_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic               irq_en_i,
  input  logic               flag_clr_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               dir_down_o,
  output logic               period_hit_o,
  output logic               zero_hit_o,
  output logic               flag_o,
  output logic               irq_o
);
  tmr_mode_e mode;
  logic      tick;
  logic      cycle_evt;

  assign mode = tmr_mode_e'(mode_i);

  tmr_tick_gen #(.NUM_SRC(NUM_SRC), .DIV_W(DIV_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_tick_i (src_tick_i),
    .src_sel_i  (src_sel_i),
    .div_sel_i  (div_sel_i),
    .run_i      (mode != MODE_STOP),
    .clr_i      (clr_i),
    .tick_o     (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .clr_i        (clr_i),
    .mode_i       (mode),
    .period_i     (period_i),
    .count_o      (count_o),
    .dir_down_o   (dir_down_o),
    .period_hit_o (period_hit_o),
    .zero_hit_o   (zero_hit_o),
    .cycle_evt_o  (cycle_evt)
  );

  tmr_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (cycle_evt),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4,
  parameter int DIV_W   = 2,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_tick_i,
  input logic [SEL_W-1:0]   src_sel_i,
  input logic [DIV_W-1:0]   div_sel_i,
  input logic [1:0]         mode_i,
  input logic               clr_i,
  input logic [CNT_W-1:0]   period_i,
  input logic               irq_en_i,
  input logic               flag_clr_i,
  input logic [CNT_W-1:0]   count_o,
  input logic               dir_down_o,
  input logic               period_hit_o,
  input logic               zero_hit_o,
  input logic               flag_o,
  input logic               irq_o
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !clr_i) |=> $stable(count_o) && $stable(dir_down_o)); // R4

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0) && !dir_down_o && !period_hit_o && !zero_hit_o); // R8

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !clr_i) |=>
      (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1))); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o); // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o); // R11

  AST_FLAG_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> (zero_hit_o || (mode_i != 2'b00))); // R10
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/tmr_core_tb.sv
module tmr_core_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick_i = '0;
  logic [1:0]  src_sel_i = '0;
  logic [1:0]  div_sel_i = '0;
  logic [1:0]  mode_i = '0;
  logic        clr_i = 1'b0;
  logic [15:0] period_i = '0;
  logic        irq_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic [15:0] count_o;
  logic        dir_down_o, period_hit_o, zero_hit_o, flag_o, irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_core u_dut (.*);

  typedef struct {
    logic [15:0] cnt;
    logic        dir;
    logic        ph;
    logic        zh;
    logic        flag;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;

  // reference state, derived from the requirements
  logic [15:0] m_cnt = '0;
  logic        m_dir = 1'b0;
  logic        m_flag = 1'b0;
  int          m_pre = 0;

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] s, input logic [1:0] sel, input logic [1:0] dv,
                      input logic [1:0] md, input logic clr, input logic [15:0] per,
                      input logic ien, input logic fclr, input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic tick, ev;
      @(negedge clk);
      src_tick_i = s; src_sel_i = sel; div_sel_i = dv; mode_i = md;
      clr_i = clr; period_i = per; irq_en_i = ien; flag_clr_i = fclr;
      tick = 1'b0; ev = 1'b0; e.ph = 1'b0; e.zh = 1'b0;
      if (clr) begin
        m_cnt = '0; m_dir = 1'b0; m_pre = 0;
      end else if (md != 2'b00 && s[sel]) begin
        m_pre = (m_pre + 1) % 8;
        tick = ((m_pre % (1 << dv)) == 0);
      end
      if (tick) begin
        case (md)
          2'b01: begin
            m_dir = 1'b0;
            if (m_cnt >= per) begin m_cnt = '0; ev = 1'b1; end
            else m_cnt = m_cnt + 16'd1;
          end
          2'b10: begin
            m_dir = 1'b0;
            if (m_cnt == 16'hFFFF) ev = 1'b1;
            m_cnt = m_cnt + 16'd1;
          end
          2'b11: begin
            if (!m_dir && m_cnt < per) begin
              m_cnt = m_cnt + 16'd1;
              if (m_cnt == per) m_dir = 1'b1;
            end else if (m_cnt <= 16'd1) begin
              m_cnt = '0; m_dir = 1'b0; ev = 1'b1;
            end else begin
              m_cnt = m_cnt - 16'd1; m_dir = 1'b1;
            end
          end
          default: ;
        endcase
        e.ph = (m_cnt == per);
        e.zh = (m_cnt == 16'd0);
      end
      if (ev) m_flag = 1'b1;
      else if (fclr) m_flag = 1'b0;
      e.cnt = m_cnt; e.dir = m_dir; e.flag = m_flag; e.irq = m_flag & ien; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // monitor: one expected item per clock, compared just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (count_o !== e.cnt) begin
          bad++;
          $display("FAIL %s count actual=%0h expected=%0h at t=%0t", e.tag, count_o, e.cnt, $time);
        end
        check_bit(e.tag, "direction", dir_down_o, e.dir);
        check_bit("R9", "period_hit", period_hit_o, e.ph);
        check_bit("R9", "zero_hit", zero_hit_o, e.zh);
        check_bit("R10", "flag", flag_o, e.flag);
        check_bit("R11", "irq", irq_o, e.irq);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        total++; bad++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    total++;
    if (count_o !== 16'd0 || dir_down_o !== 1'b0 || flag_o !== 1'b0 || irq_o !== 1'b0 ||
        period_hit_o !== 1'b0 || zero_hit_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset state actual=%0h/%0b/%0b/%0b expected=0/0/0/0",
               count_o, dir_down_o, flag_o, irq_o);
    end
    rst_n = 1'b1;

    // R5: up mode, period 5, divide by 1 on source 0
    step(4'b0001, 2'd0, 2'd0, 2'b01, 1'b0, 16'd5, 1'b0, 1'b0, "R5", 14);
    // R10: flag cleared by a pulse
    step(4'b0000, 2'd0, 2'd0, 2'b01, 1'b0, 16'd5, 1'b0, 1'b1, "R10", 1);
    // R3: every divider code in up mode
    for (int d = 1; d < 4; d++) begin
      step(4'b0001, 2'd0, 2'(d), 2'b01, 1'b1, 16'd3, 1'b0, 1'b0, "R8", 1);
      step(4'b0001, 2'd0, 2'(d), 2'b01, 1'b0, 16'd3, 1'b0, 1'b0, "R3", 40);
    end
    // R2: source 2 selected, the other sources pulse
    step(4'b0000, 2'd2, 2'd0, 2'b01, 1'b1, 16'd9, 1'b0, 1'b1, "R8", 1);
    step(4'b1011, 2'd2, 2'd0, 2'b01, 1'b0, 16'd9, 1'b0, 1'b0, "R2", 6);
    step(4'b0100, 2'd2, 2'd0, 2'b01, 1'b0, 16'd9, 1'b0, 1'b0, "R2", 4);
    // R4: stop with the divide-by-4 prescaler midway, then resume
    step(4'b0001, 2'd0, 2'd2, 2'b01, 1'b1, 16'd20, 1'b0, 1'b0, "R8", 1);
    step(4'b0001, 2'd0, 2'd2, 2'b01, 1'b0, 16'd20, 1'b0, 1'b0, "R4", 6);
    step(4'b0001, 2'd0, 2'd2, 2'b00, 1'b0, 16'd20, 1'b0, 1'b0, "R4", 7);
    step(4'b0001, 2'd0, 2'd2, 2'b01, 1'b0, 16'd20, 1'b0, 1'b0, "R4", 6);
    // R7: triangle with period 4, interrupt enabled (R11)
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b1, 16'd4, 1'b1, 1'b1, "R8", 1);
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b0, 16'd4, 1'b1, 1'b0, "R7", 20);
    // R10: clear-flag pulses on every cycle; the reach-zero cycles keep the flag set
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b0, 16'd4, 1'b1, 1'b1, "R10", 10);
    // R11: enable dropped while the flag is set
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b0, 16'd4, 1'b0, 1'b0, "R11", 4);
    // R8: clear in mid-ramp with a tick that cycle; the flag is kept
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b0, 16'd6, 1'b1, 1'b0, "R7", 3);
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b1, 16'd6, 1'b1, 1'b0, "R8", 1);
    step(4'b0001, 2'd0, 2'd0, 2'b11, 1'b0, 16'd6, 1'b1, 1'b0, "R7", 3);
    // R6: free-running through the 0xFFFF wrap
    step(4'b0000, 2'd0, 2'd0, 2'b10, 1'b1, 16'd100, 1'b1, 1'b1, "R8", 1);
    step(4'b0001, 2'd0, 2'd0, 2'b10, 1'b0, 16'd100, 1'b1, 1'b0, "R6", 65540);
    step(4'b0000, 2'd0, 2'd0, 2'b10, 1'b0, 16'd100, 1'b1, 1'b0, "R6", 2);

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule